// File: doc/BRIEF.md
# Two-Symbol Uniform-Context Interval Updater

This block sits next to the ordinary one-symbol interval update of a binary arithmetic encoder for bi-level shape data. Each cycle it sees the symbol now due and the symbol after it, with the template context of each. Contexts whose checked bits are all zero or all one are common in shape data, and their less-probable-symbol (LPS) probabilities are small fixed numbers. When both symbols share the same uniform context, the block applies both interval updates in one cycle. It does this with hard-wired constant multipliers, so it needs neither a second probability lookup nor a second general multiplier.

In every other case it updates one symbol. For a uniform context it uses the fixed constant; otherwise it uses the probability supplied from an external table. It reports how far the context front end must advance (0, 1 or 2 positions) and whether the new range needs renormalization. A pair whose first update already needs renormalization is split. The second symbol and its constant are held in registers and applied on the next committed step, while the external renormalizer works in between.

Top module: `cae_pair_updater`

## Requirements
- R1: After reset no symbol is held. A step whose current context is not uniform updates one symbol with `tbl_clps` (the LPS symbol is `tbl_lps_sym`) and reports `advance` = 1.
- R2: In intra mode (`mode`=0) all 10 context bits are checked for uniformity. In inter mode (`mode`=1) only bits 8..0 are checked, and bit 9 has no effect.
- R3: A uniform current context selects a parameter constant by mode and class: intra/all-zero, intra/all-one, inter/all-zero, inter/all-one. `tbl_clps` and `tbl_lps_sym` are then ignored. The LPS symbol is 1 for an all-zero context and 0 for an all-one context.
- R4: One update with constant c: rLPS = range[31:16]·c. An MPS gives range−rLPS and leaves low unchanged. An LPS gives low+(range−rLPS) (32-bit wrap) and range rLPS.
- R5: A pair qualifies when both contexts are uniform and identical in the checked bits. It then gets two sequential updates in one step, with `advance` = 2.
- R6: Uniform but different contexts (all-zero next to all-one) are handled as a single update with `advance` = 1.
- R7: `renorm_req` is 1 exactly when the reported range is below 0x4000_0000.
- R8: If the first update of a qualifying pair leaves the range below 0x4000_0000, only that update is reported, with `renorm_req` = 1 and `advance` = 2. The second symbol and its constant are stored on the step.
- R9: While a symbol is held, the outputs apply it to `low_in`/`range_in`, all other inputs are ignored and `advance` = 0. A committed step releases it.
- R10: If only the second update of a pair falls below 0x4000_0000, the pair completes in one step with `advance` = 2 and `renorm_req` = 1, and nothing is held.
- R11: With `step` = 0 the held state does not change, and the outputs still follow the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| step | input | 1 | commits the reported update this cycle |
| mode | input | 1 | 0 intra, 1 inter |
| sym_cur | input | 1 | symbol now due |
| sym_nxt | input | 1 | look-ahead symbol |
| ctx_cur | input | 10 | context of `sym_cur` |
| ctx_nxt | input | 10 | context of `sym_nxt` |
| tbl_clps | input | 16 | table LPS probability for a non-uniform current context |
| tbl_lps_sym | input | 1 | table LPS symbol value |
| low_in | input | 32 | current lower bound |
| range_in | input | 32 | current range |
| low_out | output | 32 | updated lower bound |
| range_out | output | 32 | updated range |
| advance | output | 2 | positions the context front end moves |
| renorm_req | output | 1 | updated range below quarter |

## Verification
Some properties are checked on every cycle. The advance code never takes its unused value and is zero whenever a symbol is held. The range never grows. The renormalization flag agrees with the reported range. A split step always leaves a held symbol, and a step on a held symbol always releases it. The bench's scenarios are what show that the arithmetic itself is right: the mode-dependent uniformity test with bit 9 masked in inter mode, the choice among the four constants, the LPS polarity per class, the split-then-resume sequence with idle cycles in between, and that reset drops a held symbol.

// File: rtl/cae_pair_pkg.sv
package cae_pair_pkg;
  localparam int RW = 32;
  localparam int PW = RW / 2;
  localparam logic [RW-1:0] QUARTER = {2'b01, {(RW-2){1'b0}}};

  typedef struct packed {
    logic [RW-1:0] low;
    logic [RW-1:0] rng;
  } ivl_t;

  // one interval update given the LPS sub-range and the symbol polarity
  function automatic ivl_t ivl_apply(ivl_t cur, logic [RW-1:0] rlps, logic is_lps);
    ivl_t nxt;
    nxt = cur;
    if (is_lps) begin
      nxt.low = cur.low + (cur.rng - rlps);
      nxt.rng = rlps;
    end else begin
      nxt.rng = cur.rng - rlps;
    end
    return nxt;
  endfunction

  function automatic logic below_quarter(logic [RW-1:0] r);
    return r < QUARTER;
  endfunction

  function automatic logic [RW-1:0] scale_hi(logic [RW-1:0] r, logic [PW-1:0] c);
    logic [2*PW-1:0] p;
    p = r[RW-1 -: PW] * c;
    return p[RW-1:0];
  endfunction
endpackage

// File: rtl/cae_ctx_uniform.sv
module cae_ctx_uniform #(
  parameter int W_INTRA = 10,
  parameter int W_INTER = 9
) (
  input  logic [W_INTRA-1:0] ctx,
  input  logic               mode,
  output logic               uniform,
  output logic               all_one
);
  localparam logic [W_INTRA-1:0] MASK_INTRA = {W_INTRA{1'b1}};
  localparam logic [W_INTRA-1:0] MASK_INTER =
    {{(W_INTRA-W_INTER){1'b0}}, {W_INTER{1'b1}}};

  logic [W_INTRA-1:0] mask;
  logic [W_INTRA-1:0] seen;

  always_comb begin
    mask    = mode ? MASK_INTER : MASK_INTRA;
    seen    = ctx & mask;
    all_one = (seen == mask);
    uniform = all_one || (seen == '0);
  end
endmodule

// File: rtl/cae_const_lane.sv
module cae_const_lane
  import cae_pair_pkg::*;
#(
  parameter logic [PW-1:0] K_INTRA_ZERO = 16'd68,
  parameter logic [PW-1:0] K_INTRA_ONE  = 16'd120,
  parameter logic [PW-1:0] K_INTER_ZERO = 16'd17,
  parameter logic [PW-1:0] K_INTER_ONE  = 16'd30
) (
  input  logic [RW-1:0] rng,
  input  logic          mode,
  input  logic          all_one,
  output logic [RW-1:0] rlps
);
  localparam int NK = 4;
  localparam logic [PW-1:0] KTAB [NK] =
    '{K_INTRA_ZERO, K_INTRA_ONE, K_INTER_ZERO, K_INTER_ONE};

  logic [RW-1:0] prod [NK];

  // one hard-wired constant product per context class
  for (genvar g = 0; g < NK; g++) begin : g_kmul
    always_comb prod[g] = scale_hi(rng, KTAB[g]);
  end

  always_comb rlps = prod[{mode, all_one}];
endmodule

// File: rtl/cae_pair_updater.sv
module cae_pair_updater
  import cae_pair_pkg::*;
#(
  parameter int W_INTRA = 10,
  parameter int W_INTER = 9,
  parameter logic [PW-1:0] K_INTRA_ZERO = 16'd68,
  parameter logic [PW-1:0] K_INTRA_ONE  = 16'd120,
  parameter logic [PW-1:0] K_INTER_ZERO = 16'd17,
  parameter logic [PW-1:0] K_INTER_ONE  = 16'd30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               mode,
  input  logic               sym_cur,
  input  logic               sym_nxt,
  input  logic [W_INTRA-1:0] ctx_cur,
  input  logic [W_INTRA-1:0] ctx_nxt,
  input  logic [PW-1:0]      tbl_clps,
  input  logic               tbl_lps_sym,
  input  logic [RW-1:0]      low_in,
  input  logic [RW-1:0]      range_in,
  output logic [RW-1:0]      low_out,
  output logic [RW-1:0]      range_out,
  output logic [1:0]         advance,
  output logic               renorm_req
);
  localparam int NL = 2;

  function automatic logic [PW-1:0] class_const(logic inter, logic one);
    case ({inter, one})
      2'b00:   return K_INTRA_ZERO;
      2'b01:   return K_INTRA_ONE;
      2'b10:   return K_INTER_ZERO;
      default: return K_INTER_ONE;
    endcase
  endfunction

  // held second symbol of a split pair
  logic          hold_v;
  logic          hold_lps;
  logic [PW-1:0] hold_k;

  // context classification, one detector per lane
  logic [W_INTRA-1:0] lane_ctx [NL];
  logic [NL-1:0]      lane_uni;
  logic [NL-1:0]      lane_one;

  always_comb begin
    lane_ctx[0] = ctx_cur;
    lane_ctx[1] = ctx_nxt;
  end

  for (genvar k = 0; k < NL; k++) begin : g_det
    cae_ctx_uniform #(.W_INTRA(W_INTRA), .W_INTER(W_INTER)) u_det (
      .ctx     (lane_ctx[k]),
      .mode    (mode),
      .uniform (lane_uni[k]),
      .all_one (lane_one[k])
    );
  end

  // named internal events
  logic uni_path;
  logic pair_ok;
  logic first_low;
  logic split_evt;

  ivl_t          iv_in, iv_first, iv_pair;
  logic [RW-1:0] rlps_k0, rlps_k1, rlps_gen, rlps0;
  logic [PW-1:0] k_gen;
  logic          lps_gen, lps0, lps1;

  always_comb begin
    iv_in.low = low_in;
    iv_in.rng = range_in;
    uni_path  = !hold_v && lane_uni[0];
    pair_ok   = !hold_v && lane_uni[0] && lane_uni[1] && (lane_one[0] == lane_one[1]);
  end

  cae_const_lane #(
    .K_INTRA_ZERO(K_INTRA_ZERO), .K_INTRA_ONE(K_INTRA_ONE),
    .K_INTER_ZERO(K_INTER_ZERO), .K_INTER_ONE(K_INTER_ONE)
  ) u_lane0 (
    .rng     (range_in),
    .mode    (mode),
    .all_one (lane_one[0]),
    .rlps    (rlps_k0)
  );

  // general path: table probability or held constant
  always_comb begin
    k_gen    = hold_v ? hold_k : tbl_clps;
    lps_gen  = hold_v ? hold_lps : (sym_cur == tbl_lps_sym);
    rlps_gen = scale_hi(range_in, k_gen);
    rlps0    = uni_path ? rlps_k0 : rlps_gen;
    lps0     = uni_path ? (sym_cur != lane_one[0]) : lps_gen;
    iv_first = ivl_apply(iv_in, rlps0, lps0);
    first_low = below_quarter(iv_first.rng);
    split_evt = pair_ok && first_low;
  end

  cae_const_lane #(
    .K_INTRA_ZERO(K_INTRA_ZERO), .K_INTRA_ONE(K_INTRA_ONE),
    .K_INTER_ZERO(K_INTER_ZERO), .K_INTER_ONE(K_INTER_ONE)
  ) u_lane1 (
    .rng     (iv_first.rng),
    .mode    (mode),
    .all_one (lane_one[1]),
    .rlps    (rlps_k1)
  );

  always_comb begin
    lps1    = (sym_nxt != lane_one[1]);
    iv_pair = ivl_apply(iv_first, rlps_k1, lps1);
    if (pair_ok && !first_low) begin
      low_out   = iv_pair.low;
      range_out = iv_pair.rng;
    end else begin
      low_out   = iv_first.low;
      range_out = iv_first.rng;
    end
    if (hold_v)       advance = 2'd0;
    else if (pair_ok) advance = 2'd2;
    else              advance = 2'd1;
    renorm_req = pair_ok ? (first_low || below_quarter(iv_pair.rng)) : first_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_lps <= 1'b0;
      hold_k   <= '0;
    end else if (step) begin
      if (hold_v) begin
        hold_v <= 1'b0;
      end else if (split_evt) begin
        hold_v   <= 1'b1;
        hold_lps <= lps1;
        hold_k   <= class_const(mode, lane_one[1]);
      end
    end
  end

  assert_adv_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance != 2'd3);
  assert_held_no_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> advance == 2'd0);
  assert_held_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hold_v) |=> !hold_v);
  assert_split_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && split_evt) |=> hold_v);
  assert_idle_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(hold_v));
  assert_range_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    range_out <= range_in);
  assert_renorm_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    renorm_req == (range_out < QUARTER));
endmodule

// File: tb/tb_cae_pair_updater.sv
module tb_cae_pair_updater;
  localparam logic [15:0] KIZ = 16'd68, KIO = 16'd120, KEZ = 16'd17, KEO = 16'd30;
  localparam logic [15:0] TBLK = 16'h1234;
  localparam logic [31:0] Q = 32'h4000_0000;
  localparam logic [31:0] LBASE = 32'h1357_9BDF;
  localparam int NV = 11;
  // fields: mode[54] ctx_cur[53:44] ctx_nxt[43:34] sym_cur[33] sym_nxt[32] range[31:0]
  localparam logic [54:0] VEC [NV] = '{
    {1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 32'h7FFF_FFFF}, // R5 intra zero pair, MPS MPS
    {1'b0, 10'h3FF, 10'h3FF, 1'b1, 1'b1, 32'h7FFF_FFFF}, // R5 R3 intra one pair, MPS MPS
    {1'b1, 10'h200, 10'h000, 1'b0, 1'b1, 32'h6000_0000}, // R2 inter bit 9 ignored
    {1'b0, 10'h200, 10'h000, 1'b0, 1'b0, 32'h6000_0000}, // R2 intra bit 9 counts
    {1'b0, 10'h000, 10'h3FF, 1'b1, 1'b0, 32'h7000_0000}, // R6 zero next to one
    {1'b1, 10'h1FF, 10'h3FF, 1'b0, 1'b1, 32'h7FFF_FFFF}, // R8 inter one pair, first LPS
    {1'b0, 10'h155, 10'h155, 1'b1, 1'b0, 32'h7FFF_FFFF}, // R1 table path
    {1'b0, 10'h000, 10'h000, 1'b1, 1'b1, 32'h7FFF_FFFF}, // R8 first LPS splits
    {1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 32'h4000_1000}, // R7 first MPS drops below
    {1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 32'h4020_0000}, // R10 second drops below
    {1'b1, 10'h0FF, 10'h0FF, 1'b0, 1'b0, 32'h7FFF_FFFF}  // R2 inter bit 8 zero
  };

  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, mode = 1'b0;
  logic sym_cur = 1'b0, sym_nxt = 1'b0, tbl_lps_sym = 1'b1;
  logic [9:0] ctx_cur = '0, ctx_nxt = '0;
  logic [15:0] tbl_clps = TBLK;
  logic [31:0] low_in = '0, range_in = 32'h7FFF_FFFF;
  logic [31:0] low_out, range_out;
  logic [1:0] advance;
  logic renorm_req;

  int total = 0, bad = 0;
  logic done = 1'b0;
  // bench-side held symbol
  logic m_hv = 1'b0, m_hl = 1'b0;
  logic [15:0] m_hk = '0;
  logic [31:0] last_low, last_rng;
  logic [1:0] last_adv;

  always #2.5 clk = ~clk;

  cae_pair_updater #(.K_INTRA_ZERO(KIZ), .K_INTRA_ONE(KIO),
                     .K_INTER_ZERO(KEZ), .K_INTER_ONE(KEO)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(mode),
    .sym_cur(sym_cur), .sym_nxt(sym_nxt), .ctx_cur(ctx_cur), .ctx_nxt(ctx_nxt),
    .tbl_clps(tbl_clps), .tbl_lps_sym(tbl_lps_sym),
    .low_in(low_in), .range_in(range_in),
    .low_out(low_out), .range_out(range_out), .advance(advance), .renorm_req(renorm_req)
  );

  function automatic logic uni(logic m, logic [9:0] c, output logic one);
    logic zero;
    if (m) begin one = &c[8:0]; zero = ~|c[8:0]; end
    else   begin one = &c;      zero = ~|c;      end
    return one | zero;
  endfunction

  function automatic logic [15:0] kof(logic m, logic one);
    if (!m) return one ? KIO : KIZ;
    return one ? KEO : KEZ;
  endfunction

  task automatic upd(inout logic [31:0] l, inout logic [31:0] r, input logic [15:0] k,
                     input logic lps);
    logic [63:0] rl;
    rl = (64'(r) / 64'd65536) * 64'(k);
    if (lps) begin l = l + (r - rl[31:0]); r = rl[31:0]; end
    else r = r - rl[31:0];
  endtask

  task automatic model(output logic [31:0] el, output logic [31:0] er, output logic [1:0] ea,
                       output logic eren, output logic split, output logic [15:0] sk,
                       output logic sl);
    logic ua, ub, oa, ob;
    el = low_in; er = range_in; split = 1'b0; sk = '0; sl = 1'b0;
    ua = uni(mode, ctx_cur, oa);
    ub = uni(mode, ctx_nxt, ob);
    if (m_hv) begin
      upd(el, er, m_hk, m_hl); ea = 2'd0;
    end else if (ua) begin
      upd(el, er, kof(mode, oa), sym_cur == !oa);
      if (ub && oa == ob) begin
        ea = 2'd2;
        if (er < Q) begin split = 1'b1; sk = kof(mode, ob); sl = (sym_nxt == !ob); end
        else upd(el, er, kof(mode, ob), sym_nxt == !ob);
      end else ea = 2'd1;
    end else begin
      upd(el, er, tbl_clps, sym_cur == tbl_lps_sym); ea = 2'd1;
    end
    eren = er < Q;
  endtask

  task automatic run(input string tag, input logic m, input logic [9:0] ca, input logic [9:0] cb,
                     input logic sa, input logic sb, input logic [31:0] l, input logic [31:0] r,
                     input logic do_step);
    logic [31:0] el, er; logic [1:0] ea; logic eren, split, sl; logic [15:0] sk;
    mode = m; ctx_cur = ca; ctx_nxt = cb; sym_cur = sa; sym_nxt = sb;
    low_in = l; range_in = r; step = do_step;
    #1;
    model(el, er, ea, eren, split, sk, sl);
    total++;
    if (low_out !== el || range_out !== er || advance !== ea || renorm_req !== eren) begin
      bad++;
      $display("FAIL %s: got low=%h rng=%h adv=%0d rn=%b exp low=%h rng=%h adv=%0d rn=%b",
               tag, low_out, range_out, advance, renorm_req, el, er, ea, eren);
    end
    last_low = low_out; last_rng = range_out; last_adv = advance;
    if (do_step) begin
      @(posedge clk);
      if (m_hv) m_hv = 1'b0;
      else if (split) begin m_hv = 1'b1; m_hk = sk; m_hl = sl; end
      @(negedge clk);
      step = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int adv_sum;
    logic [31:0] cl, cr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: no held symbol, table path advances one
    run("R1", 1'b0, 10'h155, 10'h2AA, 1'b0, 1'b0, LBASE, 32'h7FFF_FFFF, 1'b1);
    // vector table, idle so no state changes
    for (int i = 0; i < NV; i++) begin
      run("R2 R3 R4 R5 R6 R7 R8 R10 table", VEC[i][54], VEC[i][53:44], VEC[i][43:34],
          VEC[i][33], VEC[i][32], LBASE, VEC[i][31:0], 1'b0);
    end
    // R3 table inputs ignored on a uniform context
    tbl_clps = 16'hFFFF; tbl_lps_sym = 1'b0;
    run("R3", 1'b1, 10'h000, 10'h3FF, 1'b1, 1'b0, LBASE, 32'h7000_0000, 1'b0);
    tbl_clps = TBLK; tbl_lps_sym = 1'b1;
    // R8 split, R11 idle cycles keep it, R9 release
    run("R8", 1'b0, 10'h000, 10'h000, 1'b1, 1'b1, LBASE, 32'h7FFF_FFFF, 1'b1);
    run("R11", 1'b0, 10'h155, 10'h0F0, 1'b0, 1'b1, 32'h0000_0100, 32'h7F00_0000, 1'b0);
    @(negedge clk);
    run("R11", 1'b1, 10'h000, 10'h000, 1'b1, 1'b0, 32'h0000_0200, 32'h6000_0000, 1'b0);
    run("R9", 1'b1, 10'h3FF, 10'h3FF, 1'b1, 1'b1, 32'h0000_0300, 32'h7800_0000, 1'b1);
    run("R9", 1'b0, 10'h000, 10'h000, 1'b0, 1'b0, LBASE, 32'h7FFF_FFFF, 1'b0);
    // R10 second update drops below, nothing held afterwards
    run("R10", 1'b0, 10'h000, 10'h000, 1'b0, 1'b0, LBASE, 32'h4020_0000, 1'b1);
    run("R10", 1'b0, 10'h000, 10'h000, 1'b0, 1'b0, LBASE, 32'h7FFF_FFFF, 1'b0);
    // R1 reset drops a held symbol
    run("R1", 1'b1, 10'h1FF, 10'h1FF, 1'b0, 1'b0, LBASE, 32'h7FFF_FFFF, 1'b1);
    rst_n = 1'b0; m_hv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run("R1", 1'b0, 10'h3FF, 10'h3FF, 1'b1, 1'b1, LBASE, 32'h7FFF_FFFF, 1'b0);
    // R5 four qualifying pairs: eight positions in four steps
    adv_sum = 0; cl = LBASE; cr = 32'h7FFF_FFFF;
    for (int p = 0; p < 4; p++) begin
      run("R5", 1'b1, 10'h000, 10'h000, 1'b0, 1'b0, cl, cr, 1'b1);
      adv_sum += last_adv; cl = last_low; cr = last_rng;
    end
    total++;
    if (adv_sum != 8) begin
      bad++;
      $display("FAIL R5 pair run: got advance sum=%0d exp 8", adv_sum);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule